// File: doc/BRIEF.md
# Instruction Run Fetcher

This block turns one packed request word into a burst of instruction fetches. The request names a starting address and how many words to read. The block then reads that many consecutive words from a local scratch memory with synchronous read, starting at the given address and counting upward. Every word it reads is presented on an instruction output stream together with the address it came from.

Both the request input and the instruction output use valid/ready handshakes. The memory lives outside the block and returns data one cycle after it is addressed. Only one burst is in flight at a time: the block refuses a new request until the last word of the current burst has been taken downstream. It does no decoding and no routing of the words it fetches.

Top module: `runFetchTop`

## Requirements
- R1: The request word is 24 bits wide. Bits [5:0] hold the word count and bits [23:6] hold the 18-bit start address.
- R2: A request is taken on a clock edge where `descValid` and `descReady` are both high. `descReady` is high only while no burst is in progress.
- R3: A burst of count N emits exactly N words. The tags, carried on `insnAddr`, run start, start+1, …, start+N-1 in that order. Each `insnData` equals the memory word stored at its tag.
- R4: A request with count 0 is taken, produces no output word, and leaves `descReady` high on the next cycle.
- R5: `descReady` goes low in the cycle after a request with a nonzero count is taken. It stays low through the burst and is high again in the cycle after the last word's output handshake.
- R6: A read is issued by raising `memRdEn` with `memAddr` set to the address of the next word. The data on `memRdData` is captured one cycle later.
- R7: While `insnValid` is high and `insnReady` is low, `insnData` and `insnAddr` hold steady and no new memory read is issued.
- R8: The fetch address wraps from 0x3FFFF to 0x00000 inside a burst.
- R9: After reset, `insnValid` and `memRdEn` are low and `descReady` is high.
- R10: A request with the largest count, 63, emits all 63 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descValid | input | 1 | Request word valid |
| descReady | output | 1 | Block can take a request |
| descData | input | 24 | Packed request: start address and count |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | 18 | Memory read address |
| memRdData | input | 48 | Memory read data, one cycle after the strobe |
| insnValid | output | 1 | Fetched word valid |
| insnReady | input | 1 | Downstream takes the word |
| insnData | output | 48 | Fetched instruction word |
| insnAddr | output | 18 | Address the word was read from |

## Verification
The testbench runs several bursts: a short one with a plain start address, a single-word run, a run whose addresses cross the top of the address space, the full 63-word run, and a zero-count request. Comparing these shows that the count field is decoded correctly, that the start address is added correctly, and that both boundary counts are handled. Some bursts hold back `insnReady` for several cycles on chosen words, while others take each word as soon as it appears. This pairing separates output that stays stable under backpressure from output that only looks right when never stalled. The test memory returns a distinct value for every address, so a misordered, repeated or skipped word shows up as a data mismatch against its tag.

// File: rtl/runFetchPkg.sv
package runFetchPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_CAPT = 2'd2,
    ST_EMIT = 2'd3
  } fetchState_t;

  typedef struct packed {
    logic load;      // take the request fields into the run registers
    logic capture;   // latch memory data and its tag into the output stage
    logic advance;   // output word handed over: step address, drop count
    logic emitting;  // output stage holds a valid word
  } fetchStb_t;

endpackage

// File: rtl/runFetchCtrl.sv
module runFetchCtrl
  import runFetchPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      descValid,
  input  logic      zeroCnt,
  input  logic      lastWord,
  input  logic      insnReady,
  output logic      descReady,
  output logic      memRdEn,
  output logic      insnValid,
  output fetchStb_t stb
);

  fetchState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (descValid && !zeroCnt) stateNext = ST_READ;
      ST_READ: stateNext = ST_CAPT;
      ST_CAPT: stateNext = ST_EMIT;
      ST_EMIT: if (insnReady) stateNext = lastWord ? ST_IDLE : ST_READ;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign descReady    = (state == ST_IDLE);
  assign memRdEn      = (state == ST_READ);
  assign insnValid    = (state == ST_EMIT);
  assign stb.load     = descReady && descValid;
  assign stb.capture  = (state == ST_CAPT);
  assign stb.emitting = insnValid;
  assign stb.advance  = insnValid && insnReady;

  // R6: read data is captured exactly one cycle after the read strobe
  a_r6_capture_after_read: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> stb.capture);

  // R7: a stalled output issues no further read
  a_r7_no_read_in_stall: assert property (@(posedge clk) disable iff (!rstN)
    (insnValid && !insnReady) |=> !memRdEn);

  // R2: request side open only with no burst activity
  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    descReady |-> (!insnValid && !memRdEn && !stb.capture));

  // R4: an empty request leaves the request side open
  a_r4_zero_stays_ready: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && descReady && zeroCnt) |=> descReady);

endmodule

// File: rtl/runFetchPath.sv
module runFetchPath
  import runFetchPkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 6,
  parameter int WORD_W = 48,
  localparam int DESC_W = ADDR_W + CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStb_t         stb,
  input  logic [DESC_W-1:0] descData,
  input  logic [WORD_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              zeroCnt,
  output logic              lastWord,
  output logic [WORD_W-1:0] insnData,
  output logic [ADDR_W-1:0] insnAddr
);

  logic [CNT_W-1:0]  reqCnt;
  logic [ADDR_W-1:0] reqBase;
  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remCnt;

  // count sits in the low field, start address directly above it
  assign reqCnt  = descData[CNT_W-1:0];
  assign reqBase = descData[DESC_W-1:CNT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remCnt  <= '0;
    end else if (stb.load) begin
      curAddr <= reqBase;
      remCnt  <= reqCnt;
    end else if (stb.advance) begin
      curAddr <= curAddr + ADDR_W'(1);
      remCnt  <= remCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      insnData <= '0;
      insnAddr <= '0;
    end else if (stb.capture) begin
      insnData <= memRdData;
      insnAddr <= curAddr;
    end
  end

  assign memAddr  = curAddr;
  assign zeroCnt  = (reqCnt == '0);
  assign lastWord = (remCnt == CNT_W'(1));

  // R7: output word holds while the consumer stalls
  a_r7_hold_output: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emitting && !stb.advance) |=> ($stable(insnData) && $stable(insnAddr)));

  // R8: each handed-over word steps the address by one, modulo the space
  a_r8_step_address: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (curAddr == ($past(curAddr) + ADDR_W'(1))));

  // R3: the tag is the address the word was read from
  a_r3_tag_matches: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (insnAddr == $past(curAddr)));

endmodule

// File: rtl/runFetchTop.sv
module runFetchTop
  import runFetchPkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 6,
  parameter int WORD_W = 48,
  localparam int DESC_W = ADDR_W + CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descValid,
  output logic              descReady,
  input  logic [DESC_W-1:0] descData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] memRdData,
  output logic              insnValid,
  input  logic              insnReady,
  output logic [WORD_W-1:0] insnData,
  output logic [ADDR_W-1:0] insnAddr
);

  fetchStb_t stb;
  logic      zeroCnt;
  logic      lastWord;

  runFetchCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .descValid (descValid),
    .zeroCnt   (zeroCnt),
    .lastWord  (lastWord),
    .insnReady (insnReady),
    .descReady (descReady),
    .memRdEn   (memRdEn),
    .insnValid (insnValid),
    .stb       (stb)
  );

  runFetchPath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W)
  ) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .descData  (descData),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .zeroCnt   (zeroCnt),
    .lastWord  (lastWord),
    .insnData  (insnData),
    .insnAddr  (insnAddr)
  );

endmodule

// File: tb/runFetchTop_tb_top.sv
module runFetchTop_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        descValid = 1'b0;
  logic        descReady;
  logic [23:0] descData = '0;
  logic        memRdEn;
  logic [17:0] memAddr;
  logic [47:0] memRdData = '0;
  logic        insnValid;
  logic        insnReady = 1'b0;
  logic [47:0] insnData;
  logic [17:0] insnAddr;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  runFetchTop dut_i (
    .clk(clk), .rstN(rstN),
    .descValid(descValid), .descReady(descReady), .descData(descData),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .insnValid(insnValid), .insnReady(insnReady),
    .insnData(insnData), .insnAddr(insnAddr)
  );

  // test memory: a distinct word per address
  function automatic logic [47:0] memWord(input logic [17:0] a);
    return {~a, 12'hC3A, a ^ 18'h15A5A};
  endfunction

  always_ff @(posedge clk) if (memRdEn) memRdData <= memWord(memAddr);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1 R2: present a request, wait for acceptance, then check R5/R4 on ready
  task automatic sendReq(input logic [17:0] base, input logic [5:0] cnt);
    @(negedge clk);
    descData  = {base, cnt};
    descValid = 1'b1;
    while (!descReady) @(negedge clk);
    @(negedge clk);
    descValid = 1'b0;
    if (cnt == 6'd0) check(descReady == 1'b1, "R4 ready after empty request", 64'(descReady), 64'd1);
    else             check(descReady == 1'b0, "R5 ready low after accept", 64'(descReady), 64'd0);
  endtask

  // R3 R6 R7 R8: collect a burst, stalling every stallEvery-th word
  task automatic collect(input logic [17:0] base, input int cnt, input int stallEvery, input string tag);
    for (int i = 0; i < cnt; i++) begin
      logic [17:0] ea;
      logic [47:0] heldData;
      logic [17:0] heldAddr;
      int waitCnt;
      ea = base + 18'(i);
      waitCnt = 0;
      while (!insnValid && waitCnt < 20) begin
        if (memRdEn) check(memAddr == ea, {"R6 read address ", tag}, 64'(memAddr), 64'(ea));
        @(negedge clk);
        waitCnt++;
      end
      check(insnValid == 1'b1, {"R3 word present ", tag}, 64'(insnValid), 64'd1);
      check(descReady == 1'b0, {"R5 busy during burst ", tag}, 64'(descReady), 64'd0);
      if (stallEvery > 0 && (i % stallEvery) == 0) begin
        heldData = insnData;
        heldAddr = insnAddr;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          check(insnValid && insnData == heldData && insnAddr == heldAddr,
                {"R7 hold under stall ", tag}, 64'(insnData), 64'(heldData));
          check(memRdEn == 1'b0, {"R7 no read under stall ", tag}, 64'(memRdEn), 64'd0);
        end
      end
      check(insnAddr == ea, {"R3 tag ", tag}, 64'(insnAddr), 64'(ea));
      check(insnData == memWord(ea), {"R3 data ", tag}, 64'(insnData), 64'(memWord(ea)));
      insnReady = 1'b1;
      @(negedge clk);
      insnReady = 1'b0;
    end
    check(descReady == 1'b1 && insnValid == 1'b0, {"R5 ready after last word ", tag}, 64'(descReady), 64'd1);
  endtask

  task automatic testReset();
    check(insnValid == 1'b0, "R9 reset insnValid", 64'(insnValid), 64'd0);
    check(memRdEn == 1'b0, "R9 reset memRdEn", 64'(memRdEn), 64'd0);
    check(descReady == 1'b1, "R9 reset descReady", 64'(descReady), 64'd1);
  endtask

  task automatic testPlain();
    sendReq(18'h00100, 6'd5);
    collect(18'h00100, 5, 0, "plain");
  endtask

  task automatic testSingle();
    sendReq(18'h2A000, 6'd1);
    collect(18'h2A000, 1, 1, "single");
  endtask

  task automatic testStalled();
    sendReq(18'h1F0F3, 6'd7);
    collect(18'h1F0F3, 7, 2, "stalled");
  endtask

  task automatic testEmpty();
    sendReq(18'h00777, 6'd0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(insnValid == 1'b0 && memRdEn == 1'b0, "R4 nothing emitted", 64'(insnValid), 64'd0);
    end
    check(descReady == 1'b1, "R4 still ready", 64'(descReady), 64'd1);
  endtask

  task automatic testWrap();
    sendReq(18'h3FFFD, 6'd5);
    collect(18'h3FFFD, 5, 3, "R8 wrap");
  endtask

  task automatic testMax();
    sendReq(18'h01234, 6'd63);
    collect(18'h01234, 63, 16, "R10 max");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlain();
    testSingle();
    testStalled();
    testEmpty();
    testWrap();
    testMax();
    testPlain();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule